// File: doc/BRIEF.md
# Clock Synthesizer Configuration Register

This block is one 32-bit control register that sets up a clock synthesizer. It holds three things: a clock-mode selector, an input pre-divider and a feedback multiplication factor. It also applies the side effects that follow a change to the divider settings.

When software changes either divider, the block takes lock away. It then counts a programmable relock delay and reports lock again when the count runs out. If a frequency-modulation calibration is running at that moment, the block aborts it and clears the modulation depth. Modulation stays disabled until software enables it again. If the loss-of-lock reset enable is set, the block also asks for a reset.

The current clock mode decides which divider changes count. In bypass the pre-divider has no effect on lock. With the synthesizer switched off, the multiplication factor has no effect either.

The register sits on a plain single-cycle bus with no handshake. A write is taken on any clock edge where `wr_en` is high and `addr` matches. Read data is combinational while `rd_en` is high and `addr` matches, and it is zero otherwise. There is no stream interface, so no back-pressure applies. All other pins are plain control and status levels.

Top module: `pllcfg_ctrl`

## Requirements
- R1: Bit 0 of the register always reads 1, whatever was written to it. Bits 7:4, 15:12, 27:25 and 31:30 always read 0. A read with `rd_en` low or a non-matching address returns 0.
- R2: The register layout is: mode in bits 3:1, pre-divider in bits 11:8, multiplication factor in bits 23:16, modulation enable in bit 24 and modulation depth in bits 29:28. `clk_mode`, `prediv`, `mfd`, `mod_en` and `mod_depth` show the stored fields.
- R3: `cfg_invalid` becomes 1 after any accepted write whose mode is 3'b101, or whose multiplication factor is below 32 or above 132. The values 32 and 132 are valid. The write is still stored, and the flag stays 1 until reset.
- R4: After reset the register holds mode 3'b100, pre-divider 1, multiplication factor 64, modulation off and depth 0. `locked` is 0 and rises exactly RELOCK_CYC clock edges after reset is released.
- R5: An accepted write that changes a divider drops `locked` on that same clock edge. `locked` returns to 1 exactly RELOCK_CYC edges after the write.
- R6: If such a change happens while `cal_busy` is 1, `cal_abort` is high for exactly one cycle after the write, and the stored depth becomes 0 whatever depth was written.
- R7: A lock-dropping write stores modulation enable as 0, even if bit 24 was written as 1. It stays 0 until a later write sets it, and it is never set again by the block itself.
- R8: A lock-dropping write raises `rst_req` for exactly one cycle when `lol_rst_en` is 1. When `lol_rst_en` is 0 it raises nothing.
- R9: Mode bit 2 equal to 0 means bypass. In bypass a pre-divider change is stored but does not drop lock. Mode bits 2:1 equal to 00 mean off. When off, a multiplication-factor change is also stored without dropping lock.
- R10: A write that gives a divider the value it already holds is not a change. It causes no lock loss, no abort and no reset request.
- R11: A write presented in a cycle where `rst_req` is 1 is discarded, and the register is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| lol_rst_en | input | 1 | Loss-of-lock reset enable |
| cal_busy | input | 1 | Modulation calibration in progress |
| clk_mode | output | 3 | Stored clock-mode field |
| prediv | output | 4 | Stored pre-divider |
| mfd | output | 8 | Stored multiplication factor |
| locked | output | 1 | Lock model status |
| cal_abort | output | 1 | One-cycle calibration abort |
| mod_en | output | 1 | Modulation enable |
| mod_depth | output | 2 | Modulation depth |
| rst_req | output | 1 | Loss-of-lock reset request |
| cfg_invalid | output | 1 | Sticky invalid-configuration flag |

## Verification
Most faults in stored state show up on the edge right after a write. A field stored wrongly appears at once on its output pin and in the read image. A bad change decision, such as mis-gating by mode or treating a same-value write as a change, shows up on that same edge as a wrong `locked`, `rst_req` or `cal_abort`. A faulty relock counter stays hidden until the edge where `locked` should rise, so the bench compares every pin on every cycle against its model and catches an early or late rise within one cycle.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;
  localparam int MODE_W = 3;
  localparam int PDIV_W = 4;
  localparam int MFD_W  = 8;
  localparam int DEP_W  = 2;

  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [PDIV_W-1:0] pdiv_t;
  typedef logic [MFD_W-1:0]  mfd_t;
  typedef logic [DEP_W-1:0]  dep_t;

  typedef struct packed {
    mode_t mode;
    pdiv_t pdiv;
    mfd_t  mfd;
    logic  men;
    dep_t  dep;
  } cfg_t;

  localparam mode_t MODE_BAD = 3'b101;
  localparam cfg_t  CFG_RST  = '{mode: 3'b100, pdiv: 4'd1, mfd: 8'd64, men: 1'b0, dep: 2'd0};

  // bypass: the loop output is not used, so the input divider is irrelevant
  function automatic logic in_bypass(mode_t m);
    return !m[2];
  endfunction

  // off: the loop itself is stopped, so the feedback divider is irrelevant
  function automatic logic in_off(mode_t m);
    return (m[2:1] == 2'b00);
  endfunction

  function automatic logic [31:0] to_word(cfg_t c);
    return {2'b00, c.dep, 3'b000, c.men, c.mfd, 4'b0000, c.pdiv, 4'b0000, c.mode, 1'b1};
  endfunction
endpackage

// File: rtl/pllcfg_regfile.sv
module pllcfg_regfile
  import pllcfg_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 8,
  parameter int MFD_MIN  = 32,
  parameter int MFD_MAX  = 132
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              cal_busy,
  input  logic              hold,
  output cfg_t              cfg,
  output logic              relock,
  output logic              cal_abort,
  output logic              cfg_invalid
);
  localparam logic [ADDR_W-1:0] ADDR_HIT = REG_ADDR[ADDR_W-1:0];
  localparam mfd_t              MFD_LO   = MFD_MIN[MFD_W-1:0];
  localparam mfd_t              MFD_HI   = MFD_MAX[MFD_W-1:0];

  cfg_t incoming;
  logic accept, pdiv_chg, mfd_chg, bad_cfg, abort_now;
  logic unused_wbits;

  assign incoming.mode = wdata[3:1];
  assign incoming.pdiv = wdata[11:8];
  assign incoming.mfd  = wdata[23:16];
  assign incoming.men  = wdata[24];
  assign incoming.dep  = wdata[29:28];
  assign unused_wbits  = ^{wdata[31:30], wdata[27:25], wdata[15:12], wdata[7:4], wdata[0]};

  // a pending reset request freezes the register for its cycle
  assign accept    = wr_en && (addr == ADDR_HIT) && !hold;
  assign pdiv_chg  = (incoming.pdiv != cfg.pdiv) && !in_bypass(cfg.mode);
  assign mfd_chg   = (incoming.mfd != cfg.mfd) && !in_off(cfg.mode);
  assign relock    = accept && (pdiv_chg || mfd_chg);
  assign abort_now = relock && cal_busy;
  assign bad_cfg   = (incoming.mode == MODE_BAD) || (incoming.mfd < MFD_LO) ||
                     (incoming.mfd > MFD_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg         <= CFG_RST;
      cal_abort   <= 1'b0;
      cfg_invalid <= 1'b0;
    end else begin
      cal_abort <= abort_now;
      if (accept) begin
        cfg.mode <= incoming.mode;
        cfg.pdiv <= incoming.pdiv;
        cfg.mfd  <= incoming.mfd;
        cfg.men  <= relock ? 1'b0 : incoming.men;
        cfg.dep  <= abort_now ? '0 : incoming.dep;
        if (bad_cfg) cfg_invalid <= 1'b1;
      end
    end
  end

  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_abort |=> !cal_abort); // R6
  AST_ABORT_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    cal_abort |-> (cfg.dep == '0)); // R6
  AST_INVALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_invalid |=> cfg_invalid); // R3
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && wr_en) |=> $stable(cfg)); // R11
  AST_MEN_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.men && !accept) |=> !cfg.men); // R7
endmodule

// File: rtl/pllcfg_lock.sv
module pllcfg_lock #(
  parameter int RELOCK_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic relock,
  input  logic lol_en,
  output logic locked,
  output logic rst_req
);
  localparam int              CNT_W    = (RELOCK_CYC > 2) ? $clog2(RELOCK_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RELOCK_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= CNT_LOAD;
      locked  <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= relock && lol_en;
      if (relock) begin
        cnt    <= CNT_LOAD;
        locked <= 1'b0;
      end else if (!locked) begin
        if (cnt == '0) locked <= 1'b1;
        else           cnt    <= cnt - 1'b1;
      end
    end
  end

  AST_RSTREQ_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !locked); // R8
  AST_RSTREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R8
endmodule

// File: rtl/pllcfg_ctrl.sv
module pllcfg_ctrl
  import pllcfg_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int REG_ADDR   = 8,
  parameter int MFD_MIN    = 32,
  parameter int MFD_MAX    = 132,
  parameter int RELOCK_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              lol_rst_en,
  input  logic              cal_busy,
  output logic [2:0]        clk_mode,
  output logic [3:0]        prediv,
  output logic [7:0]        mfd,
  output logic              locked,
  output logic              cal_abort,
  output logic              mod_en,
  output logic [1:0]        mod_depth,
  output logic              rst_req,
  output logic              cfg_invalid
);
  localparam logic [ADDR_W-1:0] ADDR_HIT = REG_ADDR[ADDR_W-1:0];

  cfg_t cfg;
  logic relock;

  pllcfg_regfile #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .MFD_MIN(MFD_MIN), .MFD_MAX(MFD_MAX)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cal_busy(cal_busy), .hold(rst_req), .cfg(cfg), .relock(relock),
    .cal_abort(cal_abort), .cfg_invalid(cfg_invalid)
  );

  pllcfg_lock #(.RELOCK_CYC(RELOCK_CYC)) u_lock (
    .clk(clk), .rst_n(rst_n), .relock(relock), .lol_en(lol_rst_en),
    .locked(locked), .rst_req(rst_req)
  );

  assign rdata     = (rd_en && (addr == ADDR_HIT)) ? to_word(cfg) : '0;
  assign clk_mode  = cfg.mode;
  assign prediv    = cfg.pdiv;
  assign mfd       = cfg.mfd;
  assign mod_en    = cfg.men;
  assign mod_depth = cfg.dep;

  AST_CHANGE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    relock |=> !locked); // R5
  AST_RSTREQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (relock && !lol_rst_en) |=> !rst_req); // R8
  AST_ABORT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_abort |-> !locked); // R6
endmodule

// File: tb/pllcfg_ctrl_bench.sv
module pllcfg_ctrl_bench;
  localparam int RC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, lol_rst_en = 1'b0, cal_busy = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  clk_mode;
  logic [3:0]  prediv;
  logic [7:0]  mfd;
  logic [1:0]  mod_depth;
  logic        locked, cal_abort, mod_en, rst_req, cfg_invalid;

  int checks = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pllcfg_ctrl #(.RELOCK_CYC(RC)) u_pllcfg_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .lol_rst_en(lol_rst_en), .cal_busy(cal_busy),
    .clk_mode(clk_mode), .prediv(prediv), .mfd(mfd), .locked(locked),
    .cal_abort(cal_abort), .mod_en(mod_en), .mod_depth(mod_depth),
    .rst_req(rst_req), .cfg_invalid(cfg_invalid)
  );

  // reference state
  int m_mode, m_pre, m_mfd, m_men, m_dep, m_inv, m_lock, m_cnt, m_rst, m_abort;

  function automatic logic [31:0] word(int md, int pd, int mf, int me, int dp);
    return 32'(1 + (md << 1) + (pd << 8) + (mf << 16) + (me << 24) + (dp << 28));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    bit hit, chg, ab;
    int np, nm, nmode;
    cyc++;
    if (!rst_n) begin
      m_mode = 4; m_pre = 1; m_mfd = 64; m_men = 0; m_dep = 0; m_inv = 0;
      m_lock = 0; m_cnt = RC - 1; m_rst = 0; m_abort = 0;
    end else begin
      hit = wr_en && addr == 4'd8 && m_rst == 0;
      chg = 0; ab = 0;
      if (hit) begin
        nmode = int'(wdata[3:1]); np = int'(wdata[11:8]); nm = int'(wdata[23:16]);
        chg = (np != m_pre && (m_mode / 4) == 1) || (nm != m_mfd && (m_mode / 2) != 0);
        ab = chg && cal_busy;
        if (nmode == 5 || nm < 32 || nm > 132) m_inv = 1;
        m_men = chg ? 0 : int'(wdata[24]);
        m_dep = ab ? 0 : int'(wdata[29:28]);
        m_mode = nmode; m_pre = np; m_mfd = nm;
      end
      if (chg) begin m_lock = 0; m_cnt = RC - 1; end
      else if (m_lock == 0) begin
        if (m_cnt == 0) m_lock = 1; else m_cnt--;
      end
      m_rst = (chg && lol_rst_en) ? 1 : 0;
      m_abort = ab ? 1 : 0;
    end
    #1;
    check("R5 locked", 32'(locked), 32'(m_lock));
    check("R8 rst_req", 32'(rst_req), 32'(m_rst));
    check("R6 cal_abort", 32'(cal_abort), 32'(m_abort));
    check("R3 cfg_invalid", 32'(cfg_invalid), 32'(m_inv));
    check("R2 fields", {15'd0, clk_mode, prediv, mfd, mod_en, mod_depth},
          {15'd0, 3'(m_mode), 4'(m_pre), 8'(m_mfd), 1'(m_men), 2'(m_dep)});
    check("R1 rdata", rdata,
          (rd_en && addr == 4'd8) ? word(m_mode, m_pre, m_mfd, m_men, m_dep) : 32'd0);
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      bad++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      finish_run();
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [31:0] w);
    wr_en = 1'b1; addr = 4'd8; wdata = w;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    rd_en = 1'b1; addr = 4'd8;
    idle(3);
    check("R4 reset locked", 32'(locked), 32'd0);
    check("R4 reset image", rdata, word(4, 1, 64, 0, 0));
    rst_n = 1'b1;
    idle(RC - 1);
    check("R4 still unlocked", 32'(locked), 32'd0);
    idle(1);
    check("R4 locked after delay", 32'(locked), 32'd1);
    // bit0 written 0, same dividers
    wr(word(4, 1, 64, 0, 0) & 32'hFFFF_FFFE | 32'hC000_F0F0);
    check("R1 bit0 reads one", 32'(rdata[0]), 32'd1);
    check("R1 unused zero", rdata & 32'hCE00_F0F0, 32'd0);
    check("R10 same value no drop", 32'(locked), 32'd1);
    rd_en = 1'b0;
    @(negedge clk);
    check("R1 no read", rdata, 32'd0);
    rd_en = 1'b1;
    // change mfd, no reset enable
    wr(word(4, 1, 80, 0, 0));
    check("R5 dropped", 32'(locked), 32'd0);
    check("R8 no req when disabled", 32'(rst_req), 32'd0);
    idle(RC);
    check("R5 relocked", 32'(locked), 32'd1);
    wr(word(4, 1, 80, 1, 2));
    check("R2 mod fields", {30'd0, mod_en, 1'b0} | 32'(mod_depth), 32'd2 | 32'd2);
    cal_busy = 1'b1;
    wr_en = 1'b1; wdata = word(4, 2, 80, 1, 3);
    @(negedge clk);
    wr_en = 1'b0;
    check("R6 abort pulse", 32'(cal_abort), 32'd1);
    check("R6 depth cleared", 32'(mod_depth), 32'd0);
    check("R7 mod_en cleared", 32'(mod_en), 32'd0);
    @(negedge clk);
    check("R6 abort one cycle", 32'(cal_abort), 32'd0);
    cal_busy = 1'b0;
    idle(RC);
    check("R7 not re-enabled", 32'(mod_en), 32'd0);
    // reset request and blocked write
    lol_rst_en = 1'b1;
    wr_en = 1'b1; wdata = word(4, 2, 90, 0, 0);
    @(negedge clk);
    check("R8 req raised", 32'(rst_req), 32'd1);
    wdata = word(4, 2, 100, 0, 0);
    @(negedge clk);
    wr_en = 1'b0;
    check("R11 write discarded", 32'(mfd), 32'd90);
    check("R8 req one cycle", 32'(rst_req), 32'd0);
    lol_rst_en = 1'b0;
    idle(RC);
    // bypass and off gating
    wr(word(2, 2, 90, 0, 0));
    wr(word(2, 5, 90, 0, 0));
    check("R9 bypass stored", 32'(prediv), 32'd5);
    check("R9 bypass keeps lock", 32'(locked), 32'd1);
    wr(word(0, 5, 90, 0, 0));
    wr(word(0, 5, 70, 0, 0));
    check("R9 off keeps lock", 32'(locked), 32'd1);
    wr(word(4, 5, 70, 0, 0));
    // range boundaries
    wr(word(4, 5, 32, 0, 0));
    wr(word(4, 5, 132, 0, 0));
    check("R3 boundaries valid", 32'(cfg_invalid), 32'd0);
    wr(word(4, 5, 133, 0, 0));
    check("R3 above range", 32'(cfg_invalid), 32'd1);
    wr(word(4, 5, 100, 0, 0));
    check("R3 sticky", 32'(cfg_invalid), 32'd1);
    wr(word(5, 5, 100, 0, 0));
    check("R2 bad mode stored", 32'(clk_mode), 32'd5);
    idle(RC + 2);
    finish_run();
  end
endmodule